// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of an asynchronous, byte-wide parallel flash. It drives the chip-enable, write-enable and output-enable strobes (all active low), the address bus and a split data bus (output, output-enable and input). It takes one request at a time through a valid/ready port. A request is a single byte program, an erase of one 128-byte sector, or an erase of the whole array.

For each request the sequencer plays out the protected unlock write cycles the device expects. The lengths of the strobe setup, pulse and hold phases are set by parameters. It then reads the device repeatedly and watches either the toggling status bit (DQ6) or the inverted data bit (DQ7). It confirms that the status has settled before it reports completion.

Each operation type has its own cycle budget. If the budget runs out, the sequencer raises an error pulse and returns to idle. Ready stays low from acceptance until the done or error pulse.

Top module: `flash_seq_ctrl`

## Requirements
- R1: While reset is held and right after it, the strobes are inactive (`flash_ce_n`, `flash_we_n` and `flash_oe_n` all 1) and the data bus is released (`flash_dq_oe` 0). `req_ready` is 1, and `done` and `err` are 0.
- R2: A request is taken at a clock edge where `req_valid` and `req_ready` are both 1 and `req_op` is not 3. From then until the closing pulse, `req_ready` is 0, and any `req_valid` is ignored: it starts no bus cycle.
- R3: `req_op` = 3 is not an operation. It starts no bus cycle, gives no `done` or `err`, and leaves `req_ready` at 1.
- R4: A byte program (`req_op` = 0) writes, in this order: (UA, AAh), (UB, 55h), (UA, A0h), then (`req_addr`, `req_data`). UA and UB are parameters with defaults 555h and 2AAh.
- R5: A sector erase (`req_op` = 1) writes (UA, AAh), (UB, 55h), (UA, 80h), (UA, AAh), (UB, 55h), and then the sector address with 20h. The sector address is `req_addr` with its low 7 bits forced to zero.
- R6: A chip erase (`req_op` = 2) writes the same first five cycles as a sector erase, then 10h at UA.
- R7: In every write cycle, `flash_ce_n` is low and the data bus is driven for the whole cycle. Address and data are presented T_SETUP cycles before `flash_we_n` falls. `flash_we_n` stays low for T_PULSE cycles. Address and data stay unchanged for T_HOLD cycles after it rises. `flash_ce_n` then returns high for at least one cycle.
- R8: Status reads have the same shape as writes, with `flash_oe_n` taking the place of `flash_we_n`. The data bus is not driven during a read. `flash_dq_i` is captured in the last cycle of the output-enable pulse. No write happens during polling.
- R9: Toggle polling (`req_data_poll` = 0) completes once three consecutive reads return the same DQ6 (bit 6) value. That is two matching pairs: the settle and the confirming read.
- R10: Data polling (`req_data_poll` = 1) completes once two consecutive reads return DQ7 (bit 7) equal to the expected bit. The expected bit is bit 7 of `req_data` for a program and 1 for an erase. A single matching read between mismatches does not complete the operation.
- R11: A poll budget counts the cycles spent polling; it is TO_PROG, TO_SECT or TO_CHIP depending on the operation. The first status read that ends with the count at or above the budget, without completing, produces a one-cycle `err` and returns the block to idle.
- R12: `done` is a one-cycle pulse that never coincides with `err`, and `req_ready` is 1 in that same cycle. With CYC = T_SETUP+T_PULSE+T_HOLD+2, `done` is high exactly CYC×(writes+reads) cycles after the cycle following acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 none |
| req_addr | input | AW | Byte or sector address |
| req_data | input | 8 | Byte to program |
| req_data_poll | input | 1 | 1 selects DQ7 data polling, 0 selects DQ6 toggle |
| done | output | 1 | Operation completed (one-cycle pulse) |
| err | output | 1 | Poll budget expired (one-cycle pulse) |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_we_n | output | 1 | Write enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_addr | output | AW | Flash address |
| flash_dq_o | output | 8 | Data driven to the flash |
| flash_dq_oe | output | 1 | Data bus drive enable |
| flash_dq_i | input | 8 | Data read from the flash |

## Verification
Every bus cycle, whether write or read, lasts CYC = 8 clocks with the bench settings. So `done` is due exactly 8×(writes+reads) cycles after the cycle that follows acceptance. The bench counts cycles from the accepting edge and checks the completion cycle and the number of status reads against values worked out by hand for each status pattern. For the timeout case, it works out the first read whose final cycle reaches the budget and expects `err` one cycle after that read. A strobe monitor, sampling on the falling clock edge, measures the setup, pulse and hold lengths of every chip-enable window, and the write log is compared entry by entry against the expected sequences.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

   typedef enum logic [1:0] {
      OP_PROG = 2'd0,
      OP_SECT = 2'd1,
      OP_CHIP = 2'd2,
      OP_NONE = 2'd3
   } op_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SETUP,
      PH_PULSE,
      PH_HOLD
   } phase_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CMD,
      ST_POLL
   } state_e;

   localparam logic [7:0] CMD_KEY1  = 8'hAA;
   localparam logic [7:0] CMD_KEY2  = 8'h55;
   localparam logic [7:0] CMD_PROG  = 8'hA0;
   localparam logic [7:0] CMD_ERASE = 8'h80;
   localparam logic [7:0] CMD_SECT  = 8'h20;
   localparam logic [7:0] CMD_CHIP  = 8'h10;

endpackage

// File: rtl/flash_seq_cmdrom.sv
module flash_seq_cmdrom
   import flash_seq_pkg::*;
#(
   parameter int AW        = 19,
   parameter int ADDR_A    = 'h555,
   parameter int ADDR_B    = 'h2AA,
   parameter int SECT_BITS = 7
) (
   input  op_e           op,
   input  logic [2:0]    step,
   input  logic [AW-1:0] req_addr,
   input  logic [7:0]    req_data,
   output logic [AW-1:0] cyc_addr,
   output logic [7:0]    cyc_data
);
   localparam logic [AW-1:0] UA        = AW'(ADDR_A);
   localparam logic [AW-1:0] UB        = AW'(ADDR_B);
   localparam logic [AW-1:0] SECT_MASK = ~AW'((64'd1 << SECT_BITS) - 64'd1);

   initial begin
      assert (SECT_BITS < AW && ADDR_A < (64'd1 << AW) && ADDR_B < (64'd1 << AW))
         else $error("flash_seq_cmdrom: unlock address or sector size does not fit AW");
   end

   always_comb begin
      cyc_addr = UA;
      cyc_data = CMD_KEY1;
      unique case (step)
         3'd1: begin cyc_addr = UB; cyc_data = CMD_KEY2; end
         3'd2: cyc_data = (op == OP_PROG) ? CMD_PROG : CMD_ERASE;
         3'd3: if (op == OP_PROG) begin
                  cyc_addr = req_addr;
                  cyc_data = req_data;
               end
         3'd4: begin cyc_addr = UB; cyc_data = CMD_KEY2; end
         3'd5: if (op == OP_SECT) begin
                  cyc_addr = req_addr & SECT_MASK;
                  cyc_data = CMD_SECT;
               end else begin
                  cyc_data = CMD_CHIP;
               end
         default: ;
      endcase
   end

endmodule

// File: rtl/flash_seq_strobe.sv
module flash_seq_strobe
   import flash_seq_pkg::*;
#(
   parameter int AW      = 19,
   parameter int T_SETUP = 2,
   parameter int T_PULSE = 3,
   parameter int T_HOLD  = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          rd,
   input  logic [AW-1:0] addr_in,
   input  logic [7:0]    data_in,
   output logic          cyc_done,
   output logic          rvalid,
   output logic [7:0]    rdata,
   output logic          ce_n,
   output logic          we_n,
   output logic          oe_n,
   output logic [AW-1:0] addr,
   output logic [7:0]    dq_o,
   output logic          dq_oe,
   input  logic [7:0]    dq_i
);
   localparam int TMAX = (T_SETUP > T_PULSE) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                             : ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD);
   localparam int CW   = $clog2(TMAX + 1);

   initial begin
      assert (T_SETUP >= 1 && T_PULSE >= 1 && T_HOLD >= 1)
         else $error("flash_seq_strobe: phase lengths must be at least one cycle");
   end

   phase_e        ph;
   logic [CW-1:0] cnt;
   logic          rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph       <= PH_IDLE;
         cnt      <= '0;
         rd_q     <= 1'b0;
         addr     <= '0;
         dq_o     <= '0;
         rdata    <= '0;
         cyc_done <= 1'b0;
         rvalid   <= 1'b0;
      end else begin
         cyc_done <= 1'b0;
         rvalid   <= 1'b0;
         unique case (ph)
            PH_IDLE: if (start) begin
               ph   <= PH_SETUP;
               cnt  <= CW'(T_SETUP - 1);
               rd_q <= rd;
               addr <= addr_in;
               dq_o <= data_in;
            end
            PH_SETUP: if (cnt == '0) begin
               ph  <= PH_PULSE;
               cnt <= CW'(T_PULSE - 1);
            end else cnt <= cnt - 1'b1;
            PH_PULSE: if (cnt == '0) begin
               ph  <= PH_HOLD;
               cnt <= CW'(T_HOLD - 1);
               if (rd_q) rdata <= dq_i;
            end else cnt <= cnt - 1'b1;
            PH_HOLD: if (cnt == '0) begin
               ph       <= PH_IDLE;
               cyc_done <= 1'b1;
               rvalid   <= rd_q;
            end else cnt <= cnt - 1'b1;
            default: ph <= PH_IDLE;
         endcase
      end
   end

   assign ce_n  = (ph == PH_IDLE);
   assign we_n  = !((ph == PH_PULSE) && !rd_q);
   assign oe_n  = !((ph == PH_PULSE) && rd_q);
   assign dq_oe = (ph != PH_IDLE) && !rd_q;

   AST_ADDR_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_n && $past(!ce_n)) |-> ($stable(addr) && $stable(dq_o))); // R7
   AST_DATA_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (dq_oe && !ce_n)); // R7

endmodule

// File: rtl/flash_seq_poll.sv
module flash_seq_poll #(
   parameter int MATCHES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       sample_valid,
   input  logic [7:0] sample,
   input  logic       data_mode,
   input  logic       exp7,
   output logic       complete
);
   localparam int SW = $clog2(MATCHES + 1);

   initial begin
      assert (MATCHES >= 1) else $error("flash_seq_poll: MATCHES must be at least 1");
   end

   logic [SW-1:0] streak, streak_nx;
   logic          prev6, have_prev, hit;

   always_comb begin
      hit       = data_mode ? (sample[7] == exp7) : (have_prev && (sample[6] == prev6));
      streak_nx = !hit ? '0 : ((streak == SW'(MATCHES)) ? streak : streak + 1'b1);
      complete  = sample_valid && (streak_nx == SW'(MATCHES));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         streak    <= '0;
         prev6     <= 1'b0;
         have_prev <= 1'b0;
      end else if (clear) begin
         streak    <= '0;
         have_prev <= 1'b0;
      end else if (sample_valid) begin
         streak    <= streak_nx;
         prev6     <= sample[6];
         have_prev <= 1'b1;
      end
   end

   AST_STREAK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      streak <= SW'(MATCHES)); // R9

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
   import flash_seq_pkg::*;
#(
   parameter int AW        = 19,
   parameter int T_SETUP   = 2,
   parameter int T_PULSE   = 3,
   parameter int T_HOLD    = 1,
   parameter int ADDR_A    = 'h555,
   parameter int ADDR_B    = 'h2AA,
   parameter int SECT_BITS = 7,
   parameter int MATCHES   = 2,
   parameter int TO_PROG   = 5000,
   parameter int TO_SECT   = 25000,
   parameter int TO_CHIP   = 250000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [1:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [7:0]    req_data,
   input  logic          req_data_poll,
   output logic          done,
   output logic          err,
   output logic          flash_ce_n,
   output logic          flash_we_n,
   output logic          flash_oe_n,
   output logic [AW-1:0] flash_addr,
   output logic [7:0]    flash_dq_o,
   output logic          flash_dq_oe,
   input  logic [7:0]    flash_dq_i
);
   localparam int TO_MAX = (TO_PROG > TO_SECT) ? ((TO_PROG > TO_CHIP) ? TO_PROG : TO_CHIP)
                                               : ((TO_SECT > TO_CHIP) ? TO_SECT : TO_CHIP);
   localparam int TW     = $clog2(TO_MAX + 1);

   state_e        st;
   op_e           op_q;
   logic [AW-1:0] addr_q;
   logic [7:0]    data_q;
   logic          mode_q;
   logic [2:0]    step, last_step;
   logic          issue;
   logic [TW-1:0] to_cnt, lim;
   logic [AW-1:0] cyc_addr;
   logic [7:0]    cyc_data, rdata;
   logic          cyc_done, rvalid, complete, polling;

   assign polling   = (st == ST_POLL);
   assign last_step = (op_q == OP_PROG) ? 3'd3 : 3'd5;
   assign req_ready = (st == ST_IDLE);

   always_comb begin
      unique case (op_q)
         OP_SECT: lim = TW'(TO_SECT);
         OP_CHIP: lim = TW'(TO_CHIP);
         default: lim = TW'(TO_PROG);
      endcase
   end

   flash_seq_cmdrom #(.AW(AW), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B), .SECT_BITS(SECT_BITS)) u_rom (
      .op(op_q), .step(step), .req_addr(addr_q), .req_data(data_q),
      .cyc_addr(cyc_addr), .cyc_data(cyc_data)
   );

   flash_seq_strobe #(.AW(AW), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)) u_strobe (
      .clk(clk), .rst_n(rst_n), .start(issue), .rd(polling),
      .addr_in(polling ? addr_q : cyc_addr), .data_in(cyc_data),
      .cyc_done(cyc_done), .rvalid(rvalid), .rdata(rdata),
      .ce_n(flash_ce_n), .we_n(flash_we_n), .oe_n(flash_oe_n),
      .addr(flash_addr), .dq_o(flash_dq_o), .dq_oe(flash_dq_oe), .dq_i(flash_dq_i)
   );

   flash_seq_poll #(.MATCHES(MATCHES)) u_poll (
      .clk(clk), .rst_n(rst_n), .clear(st == ST_CMD), .sample_valid(rvalid),
      .sample(rdata), .data_mode(mode_q),
      .exp7((op_q == OP_PROG) ? data_q[7] : 1'b1), .complete(complete)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         op_q   <= OP_PROG;
         addr_q <= '0;
         data_q <= '0;
         mode_q <= 1'b0;
         step   <= '0;
         issue  <= 1'b0;
         to_cnt <= '0;
         done   <= 1'b0;
         err    <= 1'b0;
      end else begin
         done  <= 1'b0;
         err   <= 1'b0;
         issue <= 1'b0;
         unique case (st)
            ST_IDLE: if (req_valid && (op_e'(req_op) != OP_NONE)) begin
               op_q   <= op_e'(req_op);
               addr_q <= req_addr;
               data_q <= req_data;
               mode_q <= req_data_poll;
               step   <= '0;
               to_cnt <= '0;
               issue  <= 1'b1;
               st     <= ST_CMD;
            end
            ST_CMD: if (cyc_done) begin
               issue <= 1'b1;
               if (step == last_step) st <= ST_POLL;
               else                   step <= step + 1'b1;
            end
            ST_POLL: begin
               if (to_cnt != TW'(TO_MAX)) to_cnt <= to_cnt + 1'b1;
               if (cyc_done) begin
                  if (complete) begin
                     done <= 1'b1;
                     st   <= ST_IDLE;
                  end else if (to_cnt >= lim) begin
                     err <= 1'b1;
                     st  <= ST_IDLE;
                  end else begin
                     issue <= 1'b1;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_op != 2'd3) |=> !req_ready); // R2
   AST_NO_WRITE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
      polling |-> flash_we_n); // R8
   AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err)); // R12
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R12
   AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready); // R12
   AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> (!err && req_ready)); // R11

endmodule

// File: tb/flash_seq_ctrl_tb.sv
`timescale 1ns/1ps
module flash_seq_ctrl_tb;
   localparam int AW = 19, TS = 2, TP = 3, TH = 1;
   localparam int CYC = TS + TP + TH + 2;
   localparam int LIM_P = 300;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_data_poll = 1'b0;
   logic [1:0] req_op = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0] req_data = '0;
   logic req_ready, done, err, flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe;
   logic [AW-1:0] flash_addr;
   logic [7:0] flash_dq_o, flash_dq_i;

   always #2 clk = ~clk;

   flash_seq_ctrl #(.AW(AW), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH),
                    .TO_PROG(LIM_P), .TO_SECT(600), .TO_CHIP(900)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
      .req_data_poll(req_data_poll), .done(done), .err(err),
      .flash_ce_n(flash_ce_n), .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n),
      .flash_addr(flash_addr), .flash_dq_o(flash_dq_o), .flash_dq_oe(flash_dq_oe),
      .flash_dq_i(flash_dq_i)
   );

   int n_chk = 0, n_err = 0;

   // flash model: busy reads toggle DQ6 and invert DQ7
   int rd_total = 0, rd_base = 0, busy_n = 0, glitch_at = -1, rd_idx;
   logic [7:0] final_v = 8'h00;
   assign rd_idx = rd_total - rd_base;
   assign flash_dq_i = (rd_idx < busy_n && rd_idx != glitch_at)
                       ? {~final_v[7], rd_idx[0], final_v[5:0]} : final_v;
   always @(posedge flash_oe_n) if (rst_n) rd_total = rd_total + 1;

   // write log and protocol monitor
   logic [AW-1:0] log_a [0:255];
   logic [7:0]    log_d [0:255];
   logic [AW-1:0] fall_a;
   int n_wr = 0, proto_bad = 0;
   always @(negedge flash_we_n) if (rst_n) fall_a = flash_addr;
   always @(posedge flash_we_n) if (rst_n) begin
      log_a[n_wr[7:0]] = flash_addr;
      log_d[n_wr[7:0]] = flash_dq_o;
      if (flash_addr != fall_a || flash_ce_n) proto_bad = proto_bad + 1;
      n_wr = n_wr + 1;
   end

   int s_c = 0, p_c = 0, h_c = 0;
   bit w_seen = 0, r_seen = 0, drv = 0, nodrv = 0;
   always @(negedge clk) if (rst_n) begin
      if (flash_ce_n) begin
         if (s_c + p_c + h_c != 0) begin
            if (s_c != TS || p_c != TP || h_c != TH || (w_seen && r_seen)
                || (w_seen && nodrv) || (r_seen && drv)) proto_bad = proto_bad + 1;
         end
         s_c = 0; p_c = 0; h_c = 0; w_seen = 0; r_seen = 0; drv = 0; nodrv = 0;
      end else begin
         if (!flash_we_n || !flash_oe_n) begin
            p_c = p_c + 1;
            if (!flash_we_n) w_seen = 1; else r_seen = 1;
         end else if (p_c == 0) s_c = s_c + 1;
         else h_c = h_c + 1;
         if (flash_dq_oe) drv = 1; else nodrv = 1;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [AW+7:0] exp_wr(input int op, input int i,
                                            input logic [AW-1:0] a, input logic [7:0] d);
      logic [AW-1:0] ua = AW'('h555), ub = AW'('h2AA);
      case (i)
         0, 3: exp_wr = (op == 0 && i == 3) ? {a, d} : {ua, 8'hAA};
         1, 4: exp_wr = {ub, 8'h55};
         2:    exp_wr = {ua, (op == 0) ? 8'hA0 : 8'h80};
         default: exp_wr = (op == 1) ? {a & ~AW'('h7F), 8'h20} : {ua, 8'h10};
      endcase
   endfunction

   // issue one request; lat counts cycles from the cycle after the accepting edge
   task automatic run_op(input int op, input logic [AW-1:0] a, input logic [7:0] d,
                         input bit dpoll, input int busy, input int glitch, input logic [7:0] fin,
                         input bit poke, output int lat, output bit got_done, output bit got_err,
                         output int reads, output int wbase);
      rd_base = rd_total; busy_n = busy; glitch_at = glitch; final_v = fin; wbase = n_wr;
      proto_bad = 0;
      @(negedge clk);
      req_valid = 1; req_op = 2'(op); req_addr = a; req_data = d; req_data_poll = dpoll;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      lat = 0; got_done = 0; got_err = 0;
      while (lat < 5000) begin
         if (done || err) begin
            got_done = done; got_err = err;
            chk("R12 ready with closing pulse", 32'(req_ready), 32'd1);
            break;
         end
         if (lat == 3) chk("R2 ready low while busy", 32'(req_ready), 32'd0);
         if (poke && lat == 5) begin req_valid = 1; req_op = 2'd2; end
         if (poke && lat == 6) req_valid = 0;
         lat++;
         @(negedge clk);
      end
      reads = rd_total - rd_base;
      @(negedge clk);
      chk("R12 done is one cycle", 32'(done), 32'd0);
   endtask

   task automatic chk_writes(input string req, input int op, input logic [AW-1:0] a,
                             input logic [7:0] d, input int wbase);
      int nw = (op == 0) ? 4 : 6;
      chk({req, " write count"}, 32'(n_wr - wbase), 32'(nw));
      for (int i = 0; i < nw; i++)
         chk({req, " write entry"}, 32'({log_a[8'(wbase + i)], log_d[8'(wbase + i)]}),
             32'(exp_wr(op, i, a, d)));
      chk("R7 R8 strobe shape", 32'(proto_bad), 32'd0);
   endtask

   task automatic t_reset();
      chk("R1 ce_n", 32'(flash_ce_n), 32'd1);
      chk("R1 we_n", 32'(flash_we_n), 32'd1);
      chk("R1 oe_n", 32'(flash_oe_n), 32'd1);
      chk("R1 dq_oe", 32'(flash_dq_oe), 32'd0);
      chk("R1 ready", 32'(req_ready), 32'd1);
      chk("R1 done/err", 32'({done, err}), 32'd0);
   endtask

   task automatic t_op(input string req, input int op, input logic [AW-1:0] a,
                       input logic [7:0] d, input bit dpoll, input int busy, input int glitch,
                       input logic [7:0] fin, input bit poke, input int exp_reads);
      int lat, reads, wb; bit gd, ge;
      run_op(op, a, d, dpoll, busy, glitch, fin, poke, lat, gd, ge, reads, wb);
      chk({req, " done"}, 32'({gd, ge}), 32'b10);
      chk({req, " read count"}, 32'(reads), 32'(exp_reads));
      chk("R12 done latency", 32'(lat), 32'(CYC * ((op == 0 ? 4 : 6) + exp_reads)));
      chk_writes(op == 0 ? "R4" : (op == 1 ? "R5" : "R6"), op, a, d, wb);
   endtask

   task automatic t_op3();
      int w0 = n_wr;
      @(negedge clk);
      req_valid = 1; req_op = 2'd3;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R3 no chip enable", 32'(flash_ce_n), 32'd1);
         chk("R3 ready stays", 32'(req_ready), 32'd1);
         chk("R3 no pulse", 32'({done, err}), 32'd0);
      end
      req_valid = 0;
      chk("R3 no writes", 32'(n_wr - w0), 32'd0);
   endtask

   task automatic t_timeout();
      int lat, reads, wb, j; bit gd, ge;
      j = 0;
      while (CYC * j + CYC - 1 < LIM_P) j++;
      run_op(0, 19'h00100, 8'h11, 1'b0, 1000000, -1, 8'h11, 1'b0, lat, gd, ge, reads, wb);
      chk("R11 err not done", 32'({gd, ge}), 32'b01);
      chk("R11 err latency", 32'(lat), 32'(CYC * (4 + j + 1)));
      chk("R11 back to idle", 32'(req_ready), 32'd1);
      chk_writes("R4", 0, 19'h00100, 8'h11, wb);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      // R9 toggle settles on a matching busy value: 6 reads
      t_op("R9 toggle early", 0, 19'h12345, 8'h5A, 1'b0, 4, -1, 8'h5A, 1'b0, 6);
      // R9 toggle settles on the other value: 7 reads
      t_op("R9 toggle late", 0, 19'h00ABC, 8'h00, 1'b0, 4, -1, 8'h00, 1'b0, 7);
      // R10 data polling, program bit7 = 0; R2 request poked while busy
      t_op("R10 data poll", 0, 19'h00077, 8'h5A, 1'b1, 3, -1, 8'h5A, 1'b1, 5);
      // R10 single early match is not accepted
      t_op("R10 glitch", 0, 19'h40001, 8'h3C, 1'b1, 5, 2, 8'h3C, 1'b0, 7);
      t_op("R5 sector erase", 1, 19'h1234F, 8'h00, 1'b0, 5, -1, 8'hFF, 1'b0, 8);
      t_op("R6 chip erase", 2, 19'h00000, 8'h00, 1'b1, 2, -1, 8'hFF, 1'b0, 4);
      t_op3();
      t_timeout();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule